// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selectable Expiry Event

This block is a register-mapped watchdog. Software stores a timeout, counted in system-clock cycles, in a period register. A live down-counter, visible through the status register, runs from that period while the watchdog is enabled. Software keeps the system alive by writing anything to the status register, which reloads the counter from the period. If software stops doing so and the counter runs out, a sticky expired flag is set. One of three event outputs is then raised: a reset request, a non-maskable interrupt or a general-purpose interrupt.

Enabling uses an 8-bit key field in the control register rather than a single bit. Only one exact code stops the watchdog, so a stray write is unlikely to switch it off. A 2-bit field in the same register picks which event an expiry drives, or none. The expired flag is cleared by writing 1 to it. To recover after an expiry, software disables the watchdog, clears the flag with event selection set to none, and then enables it again with the event it wants.

Top module: `wdt_evsel`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000_0AD6, meaning disabled with event selection "none". The period register (address 1) and the status register (address 2) read 0, and all three event outputs are low.
- R2: Control bits 11:4 are the key field. The value 0xAD disables the watchdog and every other value, 0x00 included, enables it. While disabled, the counter holds its value unless the status register is written, and all event outputs stay low.
- R3: A control write that moves the key from 0xAD to any other value loads the counter from the period register at the same clock edge.
- R4: While enabled, the counter decreases by one per clock until it reads 0. With period P, the counter reads 0 P edges after the enabling edge. Control bit 15, the expired flag, is set at the next edge after that.
- R5: Any write to the status register reloads the counter from the period register, whether the watchdog is enabled or not. A reload at the edge where the counter is 0 prevents the expiry.
- R6: The expired flag stays set until a control write with bit 15 = 1 clears it. A control write with bit 15 = 0 leaves it unchanged. When an expiry and a clearing write fall on the same edge, the flag ends up set.
- R7: Control bits 2:1 pick the event: 00 drives evt_rst_o, 01 drives evt_nmi_o, 10 drives evt_gpi_o and 11 drives none. The selected output is a level that is high while the flag is set, the watchdog is enabled and the selection matches. At most one output is high at a time, and changing the selection moves the level at once.
- R8: Writing the period register while the watchdog is disabled raises no event and leaves the live counter unchanged.
- R9: Readback: address 0 returns bit 15 as the flag, bits 11:4 as the key and bits 2:1 as the selection, with all other bits 0. Address 1 returns the period, address 2 returns the live counter and address 3 returns 0.
- R10: After an expiry, the recovery sequence works as follows: writing 0x0AD0, then 0x8AD6, then an enabling key with a new selection clears the flag and restarts the count from the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 2 | Register address: 0 control, 1 period, 2 status |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| evt_rst_o | output | 1 | Reset-request event level |
| evt_nmi_o | output | 1 | Non-maskable interrupt event level |
| evt_gpi_o | output | 1 | General-purpose interrupt event level |

## Verification
The count is exercised with a short period under three patterns: a full run to expiry, steady kicks spaced well inside the period, and a kick that lands exactly on the zero count. Together these show whether the expiry edge sits one cycle past zero and whether the reload takes priority over it. The key is tried with 0x00, 0x04, 0xFF and 0xAD, with disabling in the middle of a count and with period and status writes while disabled. These cases separate "any non-0xAD value enables" from a plain enable bit, and show whether the counter truly freezes. The event field is stepped through all four codes while the flag is set, and a clear is issued on the expiry edge, so that selection decoding, the gating by enable and the set-over-clear priority can each be seen alone.

// File: rtl/wdt_evsel_pkg.sv
package wdt_evsel_pkg;
  localparam logic [7:0] KEY_OFF = 8'hAD;
  localparam int unsigned NUM_EV = 3;
  localparam int unsigned FLAG_BIT = 15;
  localparam int unsigned KEY_LSB = 4;
  localparam int unsigned KEY_W = 8;
  localparam int unsigned SEL_LSB = 1;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    EV_RST  = 2'b00,
    EV_NMI  = 2'b01,
    EV_GPI  = 2'b10,
    EV_NONE = 2'b11
  } ev_sel_e;

  typedef enum logic [1:0] {
    A_CTL  = 2'd0,
    A_PER  = 2'd1,
    A_STAT = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdt_evsel_ctl.sv
module wdt_evsel_ctl
  import wdt_evsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             flag_clr_i,
  input  logic             expire_i,
  output logic [KEY_W-1:0] key_o,
  output ev_sel_e          sel_o,
  output logic             flag_o,
  output logic             en_o,
  output logic             en_rise_o
);
  logic [KEY_W-1:0] key_q;
  ev_sel_e          sel_q;
  logic             flag_q;

  assign en_o      = (key_q != KEY_OFF);
  assign en_rise_o = we_i && !en_o && (key_i != KEY_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= KEY_OFF;
      sel_q <= EV_NONE;
    end else if (we_i) begin
      key_q <= key_i;
      sel_q <= ev_sel_e'(sel_i);
    end
  end

  // expiry wins over a write-one-to-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (expire_i)            flag_q <= 1'b1;
    else if (we_i && flag_clr_i)  flag_q <= 1'b0;
  end

  assign key_o  = key_q;
  assign sel_o  = sel_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/wdt_evsel_cnt.sv
module wdt_evsel_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             reload_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       period_q <= '0;
    else if (per_we_i) period_q <= per_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (reload_i)            cnt_q <= period_q;
    else if (en_i && !zero_o)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o   = (cnt_q == '0);
  assign period_o = period_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_evsel_evout.sv
module wdt_evsel_evout
  import wdt_evsel_pkg::*;
(
  input  logic              flag_i,
  input  logic              en_i,
  input  ev_sel_e           sel_i,
  output logic [NUM_EV-1:0] ev_o
);
  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign ev_o[g] = flag_i && en_i && (sel_i == ev_sel_e'(g));
  end
endmodule

// File: rtl/wdt_evsel.sv
module wdt_evsel
  import wdt_evsel_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              evt_rst_o,
  output logic              evt_nmi_o,
  output logic              evt_gpi_o
);
  logic             ctl_we, per_we, stat_we;
  logic [KEY_W-1:0] key;
  ev_sel_e          sel;
  logic             flag, en, en_rise, zero, expire;
  logic [CNT_W-1:0] period_q, cnt_q;
  logic [NUM_EV-1:0] ev_vec;

  assign ctl_we  = wr_en_i && (addr_i == A_CTL);
  assign per_we  = wr_en_i && (addr_i == A_PER);
  assign stat_we = wr_en_i && (addr_i == A_STAT);
  assign expire  = en && zero && !stat_we;

  wdt_evsel_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctl_we),
    .key_i      (wdata_i[KEY_LSB +: KEY_W]),
    .sel_i      (wdata_i[SEL_LSB +: SEL_W]),
    .flag_clr_i (wdata_i[FLAG_BIT]),
    .expire_i   (expire),
    .key_o      (key),
    .sel_o      (sel),
    .flag_o     (flag),
    .en_o       (en),
    .en_rise_o  (en_rise)
  );

  wdt_evsel_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_we_i (per_we),
    .per_i    (wdata_i[CNT_W-1:0]),
    .reload_i (stat_we || en_rise),
    .en_i     (en),
    .period_o (period_q),
    .cnt_o    (cnt_q),
    .zero_o   (zero)
  );

  wdt_evsel_evout u_ev (
    .flag_i (flag),
    .en_i   (en),
    .sel_i  (sel),
    .ev_o   (ev_vec)
  );

  assign evt_rst_o = ev_vec[EV_RST];
  assign evt_nmi_o = ev_vec[EV_NMI];
  assign evt_gpi_o = ev_vec[EV_GPI];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTL: begin
        rdata_o[FLAG_BIT]              = flag;
        rdata_o[KEY_LSB +: KEY_W]      = key;
        rdata_o[SEL_LSB +: SEL_W]      = sel;
      end
      A_PER:   rdata_o = DATA_W'(period_q);
      A_STAT:  rdata_o = DATA_W'(cnt_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_evsel_chk.sv
module wdt_evsel_chk
  import wdt_evsel_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              en_i,
  input logic              flag_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  period_i,
  input logic [NUM_EV-1:0] ev_i
);
  logic ctl_w, stat_w;
  assign ctl_w  = wr_en_i && (addr_i == A_CTL);
  assign stat_w = wr_en_i && (addr_i == A_STAT);

  AST_EV_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_i)); // R7

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_w && wdata_i[KEY_LSB +: KEY_W] == KEY_OFF) |=> (ev_i == '0)); // R2

  AST_OFF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_en_i) |=> $stable(cnt_i)); // R2

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && ctl_w && wdata_i[KEY_LSB +: KEY_W] != KEY_OFF)
      |=> (cnt_i == $past(period_i))); // R3

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i != '0 && !wr_en_i) |=> (cnt_i == $past(cnt_i) - CNT_W'(1))); // R4

  AST_EXPIRE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_i == '0 && !stat_w) |=> flag_i); // R4

  AST_KICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_w |=> (cnt_i == $past(period_i))); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !(ctl_w && wdata_i[FLAG_BIT])) |=> flag_i); // R6
endmodule

bind wdt_evsel wdt_evsel_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .en_i     (en),
  .flag_i   (flag),
  .cnt_i    (cnt_q),
  .period_i (period_q),
  .ev_i     (ev_vec)
);

// File: tb/wdt_evsel_tb_top.sv
module wdt_evsel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        evt_rst_o, evt_nmi_o, evt_gpi_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_evsel dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_rst_o(evt_rst_o), .evt_nmi_o(evt_nmi_o), .evt_gpi_o(evt_gpi_o)
  );

  // behavioural reference model
  int unsigned m_key = 32'hAD, m_sel = 3, m_flag = 0, m_per = 0, m_cnt = 0;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      bit en, wc, wp, ws, exp_now;
      int unsigned nkey;
      en = (m_key != 32'hAD);
      wc = wr_en_i && addr_i == 2'd0;
      wp = wr_en_i && addr_i == 2'd1;
      ws = wr_en_i && addr_i == 2'd2;
      nkey = (wdata_i >> 4) & 32'hFF;
      exp_now = en && (m_cnt == 0) && !ws;
      if (ws) m_cnt = m_per;
      else if (wc && !en && nkey != 32'hAD) m_cnt = m_per;
      else if (en && m_cnt != 0) m_cnt = m_cnt - 1;
      if (exp_now) m_flag = 1;
      else if (wc && wdata_i[15]) m_flag = 0;
      if (wc) begin m_key = nkey; m_sel = (wdata_i >> 1) & 3; end
      if (wp) m_per = wdata_i;
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = (m_flag << 15) | (m_key << 4) | (m_sel << 1);
      2'd1: m_read = m_per;
      2'd2: m_read = m_cnt;
      default: m_read = 0;
    endcase
  endfunction

  function automatic logic [2:0] m_ev();
    if (m_flag == 0 || m_key == 32'hAD || m_sel == 3) m_ev = 3'b000;
    else m_ev = 3'(1 << m_sel);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      chk("R9 model rdata", rdata_o, m_read(addr_i));
      chk("R7 model events", {29'd0, evt_gpi_o, evt_nmi_o, evt_rst_o}, {29'd0, m_ev()});
    end
  end

  // tasks are entered at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [31:0] evs();
    evs = {29'd0, evt_gpi_o, evt_nmi_o, evt_rst_o};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYCLES);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_ni = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 ctl", v, 32'h0AD6);
    rd(2'd1, v); chk("R1 period", v, 0);
    rd(2'd2, v); chk("R1 status", v, 0);
    chk("R1 events", evs(), 0);

    // R8 period write while disabled
    wr(2'd1, 5); idle(8);
    rd(2'd2, v); chk("R8 counter untouched", v, 0);
    chk("R8 no event", evs(), 0);

    // R3/R4 enable with key 0x00, NMI
    wr(2'd0, 32'h0000_0002);
    rd(2'd2, v); chk("R3 load on enable", v, 5);
    idle(1); rd(2'd2, v); chk("R4 decrement", v, 4);
    idle(3); rd(2'd2, v); chk("R4 decrement 1", v, 1);
    idle(1); rd(2'd2, v); chk("R4 zero", v, 0);
    rd(2'd0, v); chk("R4 flag not yet", v, 32'h0002);
    idle(1); rd(2'd0, v); chk("R4 flag set", v, 32'h8002);
    chk("R7 nmi level", evs(), 3'b010);

    // R6 write with bit15 = 0 keeps flag
    wr(2'd0, 32'h0000_0002);
    rd(2'd0, v); chk("R6 flag kept", v, 32'h8002);

    // R10 recovery sequence
    wr(2'd0, 32'h0000_0AD0);
    chk("R2 disabled silences", evs(), 0);
    rd(2'd0, v); chk("R10 step1", v, 32'h8AD0);
    wr(2'd0, 32'h0000_8AD6);
    rd(2'd0, v); chk("R10 step2 clear", v, 32'h0AD6);
    wr(2'd0, 32'h0000_0044);
    rd(2'd0, v); chk("R10 step3 ctl", v, 32'h0044);
    rd(2'd2, v); chk("R10 restart count", v, 5);

    // R5 kicks
    idle(3); rd(2'd2, v); chk("R5 before kick", v, 2);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd2, v); chk("R5 kick reload", v, 5);
    for (int i = 0; i < 10; i++) begin
      idle(3); wr(2'd2, 0);
    end
    rd(2'd0, v); chk("R5 kicks prevent expiry", v, 32'h0044);

    // R5 kick exactly at zero
    idle(5); rd(2'd2, v); chk("R5 at zero", v, 0);
    wr(2'd2, 0);
    rd(2'd2, v); chk("R5 zero kick reload", v, 5);
    rd(2'd0, v); chk("R5 zero kick no flag", v, 32'h0044);

    // R6 set wins over clear
    idle(5);
    wr(2'd0, 32'h0000_8044);
    rd(2'd0, v); chk("R6 set beats clear", v, 32'h8044);
    chk("R7 gpi level", evs(), 3'b100);

    // R7 selection switching
    wr(2'd0, 32'h0000_0040); chk("R7 reset level", evs(), 3'b001);
    wr(2'd0, 32'h0000_0046); chk("R7 none", evs(), 3'b000);
    rd(2'd0, v); chk("R7 ctl", v, 32'h8046);

    // R2 freeze while disabled
    wr(2'd0, 32'h0000_0AD6);
    wr(2'd0, 32'h0000_8AD6);
    wr(2'd1, 20);
    wr(2'd0, 32'h0000_0006);
    rd(2'd2, v); chk("R3 load 20", v, 20);
    idle(4); rd(2'd2, v); chk("R4 count 16", v, 16);
    wr(2'd0, 32'h0000_0AD6);
    rd(2'd2, v); chk("R2 last decrement", v, 15);
    idle(10); rd(2'd2, v); chk("R2 frozen", v, 15);
    wr(2'd1, 3);
    rd(2'd2, v); chk("R8 period write disabled", v, 15);
    chk("R8 no event", evs(), 0);
    wr(2'd2, 0);
    rd(2'd2, v); chk("R5 kick while disabled", v, 3);

    // R9 readback
    rd(2'd3, v); chk("R9 reserved", v, 0);
    wr(2'd0, 32'hFFFF_7FFF);
    rd(2'd0, v); chk("R9 ctl mask", v, 32'h0FF6);
    rd(2'd2, v); chk("R3 enable by 0xFF", v, 3);
    rd(2'd1, v); chk("R9 period", v, 3);
    idle(2);
    finish_run();
  end
endmodule